// File: doc/BRIEF.md
# Four-Digit Character Display Controller

This block holds the contents of a four-position alphanumeric display and scans them out one digit at a time. A host stores 7-bit character codes, or per-digit cursor marks, through an asynchronous parallel write port. The port has four chip enables, a cursor-select line, a 2-bit digit address, a 7-bit data bus and an active-low write strobe. The strobe, the clear line, the cursor enable and the blank line are brought into the clock domain through two-flop synchronisers before they act.

Two state machines drive the block. The write machine has the states `W_IDLE`, `W_LOW` and `W_COMMIT`. It moves from `W_IDLE` to `W_LOW` when the synchronised strobe is low and the enables match. It samples the bus in every cycle while the strobe stays low. On the synchronised rising edge it moves to `W_COMMIT`, which writes one cycle if the last sample saw valid enables, or it returns to `W_IDLE` if that sample did not. From `W_COMMIT` it always returns to `W_IDLE`.

The scan machine has one state per digit, `SC_D0`, `SC_D1`, `SC_D2` and `SC_D3`. It advances to the next state when its divider reaches `SCAN_DIV` cycles, and it goes from `SC_D3` back to `SC_D0`. For the current digit it presents a one-hot digit select, the character code, a cursor flag and a visibility flag. Font decoding and column drive sit downstream of this block.

Top module: `disp4_ctrl`

## Requirements
- R1: After reset, every digit holds code 0x20 and no cursor, and the scan shows digit 0 (`dig_sel` = 4'b0001) with `visible` high.
- R2: A write takes effect only when `ce` equals 4'b1100, that is `ce[1:0]` low and `ce[3:2]` high. Any other pattern leaves both memories unchanged.
- R3: A write with `cur_sel` low stores `din[6:0]` into the digit chosen by `addr`. Address 0 is the rightmost digit and is scanned out while `dig_sel[0]` is high; address k appears while `dig_sel[k]` is high.
- R4: Memory is updated only after `wr_n` returns high. Bus values sampled while `wr_n` is low are committed about four clock cycles after the rising edge, and nothing changes while `wr_n` stays low.
- R5: A write with `cur_sel` high sets the cursor of the addressed digit when `din[0]`=1 and removes it when `din[0]`=0. The character stored at that digit is unchanged.
- R6: While `clr_n` is low, all characters read back as 0x20 and all cursors are removed, within one full scan cycle.
- R7: With `cur_en` low, `show_cursor` is 0 and `seg_code` carries the stored character. With `cur_en` high, a digit holding a cursor drives `show_cursor`=1 and `seg_code`=0. Toggling `cur_en` never alters cursor memory.
- R8: With `blank_n` low, `visible` is 0 on every digit. Releasing it shows the same characters and cursors as before.
- R9: The scan visits digits 0, 1, 2, 3 and then 0 again, holding each one for exactly `SCAN_DIV` cycles, with exactly one bit of `dig_sel` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 4 | Chip enables; true pattern 4'b1100 |
| cur_sel | input | 1 | High: the write targets cursor memory |
| addr | input | 2 | Digit address, 0 = rightmost |
| din | input | 7 | Character code, or cursor bit on bit 0 |
| wr_n | input | 1 | Active-low write strobe, commits on rising edge |
| clr_n | input | 1 | Active-low clear of both memories |
| cur_en | input | 1 | Cursor display enable |
| blank_n | input | 1 | Active-low display blank |
| dig_sel | output | 4 | One-hot select of the digit being scanned |
| seg_code | output | 7 | Character code of the scanned digit, 0 when the cursor is shown |
| show_cursor | output | 1 | Scanned digit shows its cursor |
| visible | output | 1 | Scanned digit is lit |

## Verification
Character writes are driven at all four addresses with distinct codes. These show that each address lands on its own scanned position, with address 0 on the rightmost select. The enable patterns include the true one and patterns with a single enable wrong on each side, which separates an accepted write from a rejected one. Cursor writes are repeated with `cur_en` toggled and with data whose upper bits are set, so that a cursor mark can be told apart from a character overwrite and a display choice from a memory change. A strobe held low, a blank pulse and a clear with cursors present show when memory is allowed to change.

// File: rtl/disp4_pkg.sv
package disp4_pkg;
    localparam int NUM_DIG = 4;
    localparam int ADDR_W  = 2;
    localparam int CODE_W  = 7;
    localparam int CE_W    = 4;
    localparam logic [CE_W-1:0]   CE_TRUE    = 4'b1100;
    localparam logic [CODE_W-1:0] SPACE_CODE = 7'h20;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_LOW    = 2'd1,
        W_COMMIT = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        SC_D0 = 2'd0,
        SC_D1 = 2'd1,
        SC_D2 = 2'd2,
        SC_D3 = 2'd3
    } scan_state_e;

    typedef logic [NUM_DIG-1:0][CODE_W-1:0] char_bank_t;
endpackage

// File: rtl/disp4_sync.sv
module disp4_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/disp4_wr_fsm.sv
module disp4_wr_fsm
    import disp4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_s,
    input  logic              ce_ok,
    input  logic              cs_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CODE_W-1:0] data_in,
    output logic              we,
    output logic              w_cs,
    output logic [ADDR_W-1:0] w_addr,
    output logic [CODE_W-1:0] w_data
);
    wr_state_e state, state_nx;
    logic      cap_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= state_nx;
    end

    // bus capture while the strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ok <= 1'b0;
            w_cs   <= 1'b0;
            w_addr <= '0;
            w_data <= '0;
        end else if (!wr_s && state != W_COMMIT) begin
            cap_ok <= ce_ok;
            w_cs   <= cs_in;
            w_addr <= addr_in;
            w_data <= data_in;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            W_IDLE:   if (!wr_s && ce_ok) state_nx = W_LOW;
            W_LOW:    if (wr_s) state_nx = cap_ok ? W_COMMIT : W_IDLE;
            W_COMMIT: state_nx = W_IDLE;
            default:  state_nx = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        we = (state == W_COMMIT);
    end

    // R4: a commit only follows a strobe seen high
    a_r4_commit_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $past(wr_s));
    // R2: a sample without valid enables never commits
    a_r2_enables_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_LOW && wr_s && !cap_ok) |=> !we);
endmodule

// File: rtl/disp4_store.sv
module disp4_store
    import disp4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic              w_cs,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [CODE_W-1:0] w_data,
    output char_bank_t        chr_q,
    output logic [NUM_DIG-1:0] cur_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chr_q <= {NUM_DIG{SPACE_CODE}};
            cur_q <= '0;
        end else if (clr) begin
            chr_q <= {NUM_DIG{SPACE_CODE}};
            cur_q <= '0;
        end else if (we) begin
            if (w_cs) cur_q[w_addr] <= w_data[0];
            else      chr_q[w_addr] <= w_data;
        end
    end

    // R5: a cursor write leaves the characters alone
    a_r5_cursor_keeps_chars: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_cs && !clr) |=> chr_q == $past(chr_q));

    // R6: clear empties every position
    for (genvar g = 0; g < NUM_DIG; g++) begin : g_clr_chk
        a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (chr_q[g] == SPACE_CODE && !cur_q[g]));
    end
endmodule

// File: rtl/disp4_scan.sv
module disp4_scan
    import disp4_pkg::*;
#(
    parameter int SCAN_DIV = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_DIG-1:0] dig_sel,
    output logic [ADDR_W-1:0]  idx
);
    localparam int DIV_W = $clog2(SCAN_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);

    scan_state_e      state, state_nx;
    logic [DIV_W-1:0] div_cnt;
    logic             tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end

    assign tick = (div_cnt == DIV_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SC_D0;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (tick) begin
            unique case (state)
                SC_D0: state_nx = SC_D1;
                SC_D1: state_nx = SC_D2;
                SC_D2: state_nx = SC_D3;
                SC_D3: state_nx = SC_D0;
                default: state_nx = SC_D0;
            endcase
        end
    end

    // outputs
    always_comb begin
        dig_sel = '0;
        idx     = '0;
        unique case (state)
            SC_D0: begin dig_sel = 4'b0001; idx = 2'd0; end
            SC_D1: begin dig_sel = 4'b0010; idx = 2'd1; end
            SC_D2: begin dig_sel = 4'b0100; idx = 2'd2; end
            SC_D3: begin dig_sel = 4'b1000; idx = 2'd3; end
            default: begin dig_sel = 4'b0001; idx = 2'd0; end
        endcase
    end

    // R9: the digit holds between divider wraps
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dig_sel));
    // R9: digit 3 wraps to digit 0
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel[3] && tick) |=> dig_sel[0]);
    // R9: the divider stays in range
    a_r9_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= DIV_LAST);
endmodule

// File: rtl/disp4_ctrl.sv
module disp4_ctrl
    import disp4_pkg::*;
#(
    parameter int SCAN_DIV = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  ce,
    input  logic        cur_sel,
    input  logic [1:0]  addr,
    input  logic [6:0]  din,
    input  logic        wr_n,
    input  logic        clr_n,
    input  logic        cur_en,
    input  logic        blank_n,
    output logic [3:0]  dig_sel,
    output logic [6:0]  seg_code,
    output logic        show_cursor,
    output logic        visible
);
    logic [3:0] async_in, sync_out;
    logic       wr_s, clr_s, cue_s, bl_s;

    assign async_in = {blank_n, cur_en, clr_n, wr_n};

    disp4_sync #(.W(4), .RST_VAL(4'b1011)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
    );

    assign wr_s  = sync_out[0];
    assign clr_s = sync_out[1];
    assign cue_s = sync_out[2];
    assign bl_s  = sync_out[3];

    logic              we, w_cs;
    logic [ADDR_W-1:0] w_addr;
    logic [CODE_W-1:0] w_data;

    disp4_wr_fsm u_wr (
        .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .ce_ok(ce == CE_TRUE),
        .cs_in(cur_sel), .addr_in(addr), .data_in(din),
        .we(we), .w_cs(w_cs), .w_addr(w_addr), .w_data(w_data)
    );

    char_bank_t         chr_q;
    logic [NUM_DIG-1:0] cur_q;

    disp4_store u_store (
        .clk(clk), .rst_n(rst_n), .clr(!clr_s), .we(we), .w_cs(w_cs),
        .w_addr(w_addr), .w_data(w_data), .chr_q(chr_q), .cur_q(cur_q)
    );

    logic [ADDR_W-1:0] idx;

    disp4_scan #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk(clk), .rst_n(rst_n), .dig_sel(dig_sel), .idx(idx)
    );

    always_comb begin
        show_cursor = cue_s && cur_q[idx];
        seg_code    = show_cursor ? '0 : chr_q[idx];
        visible     = bl_s;
    end

    // R7: cursor enable low never shows a cursor
    a_r7_cursor_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cue_s |-> !show_cursor);
    // R8: blank low darkens every digit
    a_r8_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !bl_s |-> !visible);
endmodule

// File: tb/sim_disp4_ctrl.sv
module sim_disp4_ctrl;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ce = 4'b0000;
    logic       cur_sel = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [6:0] din = 7'd0;
    logic       wr_n = 1'b1;
    logic       clr_n = 1'b1;
    logic       cur_en = 1'b0;
    logic       blank_n = 1'b1;
    logic [3:0] dig_sel;
    logic [6:0] seg_code;
    logic       show_cursor;
    logic       visible;

    int checks = 0;
    int fails  = 0;
    logic [6:0] model [4];

    always #4 clk = ~clk;

    disp4_ctrl #(.SCAN_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .cur_sel(cur_sel), .addr(addr),
        .din(din), .wr_n(wr_n), .clr_n(clr_n), .cur_en(cur_en),
        .blank_n(blank_n), .dig_sel(dig_sel), .seg_code(seg_code),
        .show_cursor(show_cursor), .visible(visible)
    );

    // vector: {ce[3:0], cur_sel, addr[1:0], din[6:0]}
    localparam logic [13:0] VEC [8] = '{
        {4'b1100, 1'b0, 2'd0, 7'h41},
        {4'b1100, 1'b0, 2'd1, 7'h42},
        {4'b1100, 1'b0, 2'd2, 7'h43},
        {4'b1100, 1'b0, 2'd3, 7'h44},
        {4'b1110, 1'b0, 2'd0, 7'h55},
        {4'b0100, 1'b0, 2'd1, 7'h66},
        {4'b1000, 1'b0, 2'd2, 7'h77},
        {4'b1100, 1'b0, 2'd3, 7'h7F}
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] c, input logic cs,
                            input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        ce = c; cur_sel = cs; addr = a; din = d;
        cyc(1);
        wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1;
        cyc(4);
        ce = 4'b0000; cur_sel = 1'b0;
        cyc(3);
    endtask

    // wait for digit k to be scanned, then check its outputs
    task automatic read_digit(input string req, input int k, input int exp_code,
                              input int exp_cur, input int exp_vis);
        int guard = 0;
        @(negedge clk);
        while (dig_sel != (4'b0001 << k) && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        check(req, $sformatf("dig_sel for digit %0d", k), dig_sel, 4'b0001 << k);
        check(req, $sformatf("seg_code digit %0d", k), seg_code, exp_code);
        check(req, $sformatf("show_cursor digit %0d", k), show_cursor, exp_cur);
        check(req, $sformatf("visible digit %0d", k), visible, exp_vis);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 7'h20;
        cyc(3);
        // R1: reset state, scan starts at digit 0
        check("R1", "dig_sel in reset", dig_sel, 4'b0001);
        rst_n = 1'b1;
        cyc(1);
        check("R1", "dig_sel after reset", dig_sel, 4'b0001);
        for (int k = 0; k < 4; k++) read_digit("R1", k, 7'h20, 0, 1);

        // R9: scan order and dwell
        begin
            int cnt;
            logic [3:0] prev;
            while (dig_sel != 4'b0001) @(negedge clk);
            while (dig_sel == 4'b0001) @(negedge clk);
            for (int s = 0; s < 5; s++) begin
                prev = dig_sel;
                cnt = 0;
                while (dig_sel == prev && cnt < 50) begin
                    @(negedge clk);
                    cnt++;
                end
                check("R9", "dwell cycles", cnt, DIV);
                check("R9", "next digit",
                      dig_sel, (prev == 4'b1000) ? 4'b0001 : (prev << 1));
            end
        end

        // R2 / R3: table of writes
        for (int v = 0; v < 8; v++) begin
            logic [3:0] vc;
            logic [1:0] va;
            logic [6:0] vd;
            {vc, va, vd} = {VEC[v][13:10], VEC[v][8:7], VEC[v][6:0]};
            do_write(vc, VEC[v][9], va, vd);
            if (vc == 4'b1100) model[va] = vd;
            read_digit(vc == 4'b1100 ? "R3" : "R2", int'(va), model[va], 0, 1);
        end
        // R3: address 0 is the rightmost digit
        for (int k = 0; k < 4; k++) read_digit("R3", k, model[k], 0, 1);

        // R4: nothing lands while the strobe stays low
        @(negedge clk);
        ce = 4'b1100; addr = 2'd0; din = 7'h30;
        cyc(1);
        wr_n = 1'b0;
        cyc(20);
        read_digit("R4", 0, 7'h41, 0, 1);
        wr_n = 1'b1;
        cyc(4);
        ce = 4'b0000;
        cyc(3);
        model[0] = 7'h30;
        read_digit("R4", 0, 7'h30, 0, 1);

        // R5 / R7: cursor memory and cursor enable
        cur_en = 1'b1;
        do_write(4'b1100, 1'b1, 2'd1, 7'h01);
        read_digit("R5", 1, 0, 1, 1);
        read_digit("R7", 0, 7'h30, 0, 1);
        cur_en = 1'b0;
        cyc(3);
        read_digit("R7", 1, 7'h42, 0, 1);
        cur_en = 1'b1;
        cyc(3);
        read_digit("R7", 1, 0, 1, 1);
        do_write(4'b1100, 1'b1, 2'd1, 7'h7E);
        read_digit("R5", 1, 7'h42, 0, 1);

        // R8: blank darkens but keeps memory
        do_write(4'b1100, 1'b1, 2'd2, 7'h01);
        blank_n = 1'b0;
        cyc(3);
        read_digit("R8", 2, 0, 1, 0);
        read_digit("R8", 3, 7'h7F, 0, 0);
        blank_n = 1'b1;
        cyc(3);
        read_digit("R8", 2, 0, 1, 1);
        read_digit("R8", 3, 7'h7F, 0, 1);

        // R6: clear both memories within one scan cycle
        clr_n = 1'b0;
        cyc(3 + 4 * DIV);
        for (int k = 0; k < 4; k++) read_digit("R6", k, 7'h20, 0, 1);
        clr_n = 1'b1;
        cyc(3);
        for (int k = 0; k < 4; k++) read_digit("R6", k, 7'h20, 0, 1);

        finish_up();
    end
endmodule